// File: doc/BRIEF.md
# Interrupt Acceptance Sequencer

This block sits beside a small 8-bit processor core and decides, one request at a time, whether an interrupt is taken. It watches a level-sensitive maskable request and an edge-triggered non-maskable request. When it takes one, it tells the core to clear the interrupt-enable flag, to leave the halt state and to push a return address. It also produces the new program counter.

The maskable request is only honoured while the core reports its enable flag as set. The non-maskable request is always honoured. Depending on the interrupt mode, the new program counter is either a fixed restart address or a 16-bit word fetched from a vector table. The table address is built from the page register and the byte that the interrupting device places on the data bus. The table fetch uses a request/acknowledge handshake to the memory side.

After every acceptance the sequencer spends one guard cycle ignoring requests. This gives the core time to apply the cleared enable flag.

Top module: `irq_accept_seq`

## Requirements
- R1: While reset is held and after it is released, with no request present, taken, nmi_taken, push_valid, clr_iff1, exit_halt, iff2_we, vec_rd_req and pc_load are all 0, and pc_new reads 0x0000.
- R2: A maskable request while iff1_in is 0 is rejected. No taken, push, pc_load, table read or clr_iff1 pulse appears in the following cycle.
- R3: On every acceptance, taken, push_valid and clr_iff1 pulse high for one cycle, starting in the cycle after the request is sampled.
- R4: The pushed return address is pc_in + 1 (modulo 65536) when halted_in is 1, in which case exit_halt pulses. It is pc_in unchanged when halted_in is 0.
- R5: In int_mode 0, 1 or 3 a maskable acceptance loads pc_new = 0x0038 with pc_load, in the same cycle as taken.
- R6: In int_mode 2 a maskable acceptance raises vec_rd_req with vec_rd_addr = {i_reg, bus_vec}, where i_reg is bits 15:8 and bus_vec is bits 7:0. Request and address hold until vec_rd_ack is sampled high. In the next cycle, pc_load pulses with pc_new equal to the vec_rd_data sampled with the acknowledge, and vec_rd_req is low.
- R7: A rising edge on nmi_req is taken regardless of iff1_in. It raises nmi_taken, loads pc_new = 0x0066, and pulses iff2_we with iff2_val equal to iff1_in at acceptance.
- R8: When the NMI edge and an enabled maskable request are sampled in the same cycle, the NMI is taken and no table read starts.
- R9: An nmi_req held high is taken only once. An NMI edge that arrives while a table fetch is in progress is remembered and taken once the sequencer is free again.
- R10: taken is never high in two consecutive cycles. After a fixed-address acceptance, a held request is taken again two cycles later at the earliest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Maskable request, level |
| nmi_req | input | 1 | Non-maskable request, rising edge |
| bus_vec | input | 8 | Byte supplied by the interrupting device |
| int_mode | input | 2 | Interrupt mode (2 selects table vectoring) |
| i_reg | input | 8 | Vector-table page register |
| pc_in | input | 16 | Current program counter |
| halted_in | input | 1 | Core is in the halt state |
| iff1_in | input | 1 | Current interrupt-enable flag |
| vec_rd_ack | input | 1 | Table read acknowledge |
| vec_rd_data | input | 16 | Table word, valid with vec_rd_ack |
| taken | output | 1 | Interrupt accepted (one-cycle pulse) |
| nmi_taken | output | 1 | Accepted interrupt is the NMI |
| push_valid | output | 1 | Push the return address |
| push_data | output | 16 | Return address to push |
| clr_iff1 | output | 1 | Clear the interrupt-enable flag |
| exit_halt | output | 1 | Leave the halt state |
| iff2_we | output | 1 | Write the shadow enable flag |
| iff2_val | output | 1 | Value for the shadow enable flag |
| vec_rd_req | output | 1 | Table read request, held until acknowledged |
| vec_rd_addr | output | 16 | Table read address |
| pc_load | output | 1 | Load pc_new into the program counter |
| pc_new | output | 16 | New program counter |

## Verification
A wrong state or a corrupt pending-NMI latch shows at the ports within two cycles of a request. Symptoms include a missing or doubled taken pulse, a taken pulse in the guard cycle, or a request that is lost while a table fetch stalls. A wrong return address or target shows on push_data or pc_new in the very cycle of the taken pulse. A fault in the table path shows either as a vec_rd_addr that drifts while acknowledge is low, or as a pc_load that fails to follow the acknowledge by exactly one cycle.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  parameter int unsigned BYTE_W = 8;
  parameter int unsigned ADDR_W = 2 * BYTE_W;
  parameter int unsigned MODE_W = 2;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FETCH = 2'd1,
    SQ_GUARD = 2'd2
  } sq_state_e;

  // Return address: step past the halt opcode when the core is parked on it.
  function automatic logic [ADDR_W-1:0] resume_addr(input logic [ADDR_W-1:0] pc,
                                                    input logic halted);
    return pc + {{(ADDR_W-1){1'b0}}, halted};
  endfunction

  // Table pointer: page register supplies the high byte, device byte the low.
  function automatic logic [ADDR_W-1:0] table_ptr(input logic [BYTE_W-1:0] page,
                                                  input logic [BYTE_W-1:0] slot);
    return {page, slot};
  endfunction

  function automatic logic mode_uses_table(input logic [MODE_W-1:0] mode);
    return mode == MODE_W'(2);
  endfunction

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_req,
  input  logic consume,
  output logic fire
);
  logic nmi_q;
  logic pend;
  logic rise;

  assign rise = nmi_req & ~nmi_q;
  assign fire = pend | rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      nmi_q <= nmi_req;
      pend  <= fire & ~consume;
    end
  end

  // R9
  nmi_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> !pend || $rose(nmi_req));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter (
  input  logic idle,
  input  logic nmi_fire,
  input  logic irq_req,
  input  logic iff1,
  output logic accept,
  output logic sel_nmi
);
  logic take_mask;

  // NMI wins over a simultaneous maskable request.
  assign sel_nmi   = idle & nmi_fire;
  assign take_mask = idle & ~nmi_fire & irq_req & iff1;
  assign accept    = sel_nmi | take_mask;

endmodule

// File: rtl/irq_target_calc.sv
module irq_target_calc
  import irq_seq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MASK_PC = 16'h0038,
  parameter logic [ADDR_W-1:0] NMI_PC  = 16'h0066
) (
  input  logic              sel_nmi,
  input  logic [MODE_W-1:0] mode,
  input  logic [BYTE_W-1:0] page,
  input  logic [BYTE_W-1:0] slot,
  output logic              use_table,
  output logic [ADDR_W-1:0] fixed_pc,
  output logic [ADDR_W-1:0] tbl_addr
);
  assign use_table = ~sel_nmi & mode_uses_table(mode);
  assign fixed_pc  = sel_nmi ? NMI_PC : MASK_PC;
  assign tbl_addr  = table_ptr(page, slot);

endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
  import irq_seq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MASK_PC = 16'h0038,
  parameter logic [ADDR_W-1:0] NMI_PC  = 16'h0066
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic              nmi_req,
  input  logic [BYTE_W-1:0] bus_vec,
  input  logic [MODE_W-1:0] int_mode,
  input  logic [BYTE_W-1:0] i_reg,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              halted_in,
  input  logic              iff1_in,
  input  logic              vec_rd_ack,
  input  logic [ADDR_W-1:0] vec_rd_data,
  output logic              taken,
  output logic              nmi_taken,
  output logic              push_valid,
  output logic [ADDR_W-1:0] push_data,
  output logic              clr_iff1,
  output logic              exit_halt,
  output logic              iff2_we,
  output logic              iff2_val,
  output logic              vec_rd_req,
  output logic [ADDR_W-1:0] vec_rd_addr,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_new
);
  sq_state_e         state;
  logic              idle;
  logic              nmi_fire;
  logic              accept;
  logic              sel_nmi;
  logic              nmi_consume;
  logic              use_table;
  logic [ADDR_W-1:0] fixed_pc;
  logic [ADDR_W-1:0] tbl_addr;

  assign idle        = (state == SQ_IDLE);
  assign nmi_consume = accept & sel_nmi;

  irq_nmi_latch u_nmi (
    .clk     (clk),
    .rst_n   (rst_n),
    .nmi_req (nmi_req),
    .consume (nmi_consume),
    .fire    (nmi_fire)
  );

  irq_arbiter u_arb (
    .idle     (idle),
    .nmi_fire (nmi_fire),
    .irq_req  (irq_req),
    .iff1     (iff1_in),
    .accept   (accept),
    .sel_nmi  (sel_nmi)
  );

  irq_target_calc #(
    .MASK_PC (MASK_PC),
    .NMI_PC  (NMI_PC)
  ) u_tgt (
    .sel_nmi   (sel_nmi),
    .mode      (int_mode),
    .page      (i_reg),
    .slot      (bus_vec),
    .use_table (use_table),
    .fixed_pc  (fixed_pc),
    .tbl_addr  (tbl_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= SQ_IDLE;
      taken       <= 1'b0;
      nmi_taken   <= 1'b0;
      push_valid  <= 1'b0;
      push_data   <= '0;
      clr_iff1    <= 1'b0;
      exit_halt   <= 1'b0;
      iff2_we     <= 1'b0;
      iff2_val    <= 1'b0;
      vec_rd_req  <= 1'b0;
      vec_rd_addr <= '0;
      pc_load     <= 1'b0;
      pc_new      <= '0;
    end else begin
      taken      <= 1'b0;
      nmi_taken  <= 1'b0;
      push_valid <= 1'b0;
      clr_iff1   <= 1'b0;
      exit_halt  <= 1'b0;
      iff2_we    <= 1'b0;
      pc_load    <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (accept) begin
            taken      <= 1'b1;
            nmi_taken  <= sel_nmi;
            push_valid <= 1'b1;
            push_data  <= resume_addr(pc_in, halted_in);
            clr_iff1   <= 1'b1;
            exit_halt  <= halted_in;
            if (sel_nmi) begin
              iff2_we  <= 1'b1;
              iff2_val <= iff1_in;
            end
            if (use_table) begin
              vec_rd_req  <= 1'b1;
              vec_rd_addr <= tbl_addr;
              state       <= SQ_FETCH;
            end else begin
              pc_load <= 1'b1;
              pc_new  <= fixed_pc;
              state   <= SQ_GUARD;
            end
          end
        end
        SQ_FETCH: begin
          if (vec_rd_ack) begin
            vec_rd_req <= 1'b0;
            pc_load    <= 1'b1;
            pc_new     <= vec_rd_data;
            state      <= SQ_GUARD;
          end
        end
        SQ_GUARD: state <= SQ_IDLE;
        default:  state <= SQ_IDLE;
      endcase
    end
  end

  // R3
  push_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> (clr_iff1 && taken));

  // R10
  no_back2back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> !taken);

  // R6
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd_req && !vec_rd_ack) |=> (vec_rd_req && $stable(vec_rd_addr)));

  // R6
  table_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd_req && vec_rd_ack) |=> (pc_load && !vec_rd_req && !taken));

  // R7
  iff2_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iff2_we |-> (nmi_taken && pc_load));

  // R2
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !nmi_taken) |-> $past(iff1_in));

  // R5
  fixed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !vec_rd_req) |-> pc_load);

endmodule

// File: tb/tb_irq_accept_seq.sv
module tb_irq_accept_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0, nmi_req = 1'b0;
  logic [7:0]  bus_vec = '0, i_reg = '0;
  logic [1:0]  int_mode = '0;
  logic [15:0] pc_in = '0, vec_rd_data = '0;
  logic        halted_in = 1'b0, iff1_in = 1'b0, vec_rd_ack = 1'b0;
  logic        taken, nmi_taken, push_valid, clr_iff1, exit_halt;
  logic        iff2_we, iff2_val, vec_rd_req, pc_load;
  logic [15:0] push_data, vec_rd_addr, pc_new;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_accept_seq dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
    .bus_vec(bus_vec), .int_mode(int_mode), .i_reg(i_reg), .pc_in(pc_in),
    .halted_in(halted_in), .iff1_in(iff1_in), .vec_rd_ack(vec_rd_ack),
    .vec_rd_data(vec_rd_data), .taken(taken), .nmi_taken(nmi_taken),
    .push_valid(push_valid), .push_data(push_data), .clr_iff1(clr_iff1),
    .exit_halt(exit_halt), .iff2_we(iff2_we), .iff2_val(iff2_val),
    .vec_rd_req(vec_rd_req), .vec_rd_addr(vec_rd_addr), .pc_load(pc_load),
    .pc_new(pc_new)
  );

  typedef struct packed {
    logic        irq;
    logic        nmi;
    logic        iff1;
    logic [1:0]  mode;
    logic        halted;
    logic [15:0] pc;
    logic [7:0]  vec;
    logic [7:0]  page;
    logic        exp_take;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 16'h1234, 8'h00, 8'h00, 1'b1},
    '{1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 16'h4000, 8'h00, 8'h00, 1'b1},
    '{1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 16'h2222, 8'h00, 8'h00, 1'b0},
    '{1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 16'h8000, 8'h10, 8'h3F, 1'b1},
    '{1'b1, 1'b0, 1'b1, 2'd2, 1'b1, 16'hFFFF, 8'hFE, 8'h80, 1'b1},
    '{1'b0, 1'b1, 1'b0, 2'd2, 1'b0, 16'h0100, 8'h22, 8'h11, 1'b1},
    '{1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 16'h0AB0, 8'h44, 8'h55, 1'b1},
    '{1'b1, 1'b0, 1'b1, 2'd3, 1'b0, 16'h7777, 8'h00, 8'h00, 1'b1},
    '{1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 16'h3333, 8'h00, 8'h00, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] model_ret(input logic [15:0] pc, input logic h);
    return h ? pc + 16'd1 : pc;
  endfunction

  function automatic logic [15:0] model_word(input logic [7:0] pg, input logic [7:0] sl);
    return {pg, sl} ^ 16'h5A5A;
  endfunction

  task automatic quiet();
    irq_req = 1'b0; nmi_req = 1'b0; vec_rd_ack = 1'b0;
    step(); step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: outputs idle during and after reset
    step(); step();
    check("R1 taken in reset", {31'd0, taken}, 0);
    check("R1 pc_load in reset", {31'd0, pc_load}, 0);
    rst_n = 1'b1;
    step();
    check("R1 pulses after reset",
          {24'd0, taken, nmi_taken, push_valid, clr_iff1, exit_halt, iff2_we, vec_rd_req, pc_load}, 0);
    check("R1 pc_new after reset", {16'd0, pc_new}, 0);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      vec_t e;
      logic tbl;
      logic [15:0] w;
      e = TBL[k];
      irq_req = e.irq; nmi_req = e.nmi; iff1_in = e.iff1; int_mode = e.mode;
      halted_in = e.halted; pc_in = e.pc; bus_vec = e.vec; i_reg = e.page;
      tbl = !e.nmi && (e.mode == 2'd2);
      step();
      if (e.exp_take) begin
        check("R3 taken", {31'd0, taken}, 1);
        check("R3 clr_iff1", {31'd0, clr_iff1}, 1);
        check("R3 push_valid", {31'd0, push_valid}, 1);
        check("R4 push_data", {16'd0, push_data}, {16'd0, model_ret(e.pc, e.halted)});
        check("R4 exit_halt", {31'd0, exit_halt}, {31'd0, e.halted});
        check("R7 nmi_taken", {31'd0, nmi_taken}, {31'd0, e.nmi});
        check("R7 iff2_we", {31'd0, iff2_we}, {31'd0, e.nmi});
        if (e.nmi) begin
          check("R7 iff2_val", {31'd0, iff2_val}, {31'd0, e.iff1});
          check("R7 R8 nmi target", {15'd0, pc_load, pc_new}, {15'd0, 1'b1, 16'h0066});
          check("R8 no table read", {31'd0, vec_rd_req}, 0);
        end else if (tbl) begin
          check("R6 vec_rd_req", {31'd0, vec_rd_req}, 1);
          check("R6 vec_rd_addr", {16'd0, vec_rd_addr}, {16'd0, e.page, e.vec});
          check("R6 no early load", {31'd0, pc_load}, 0);
          irq_req = 1'b0;
          w = model_word(e.page, e.vec);
          vec_rd_data = w;
          vec_rd_ack = 1'b1;
          step();
          vec_rd_ack = 1'b0;
          check("R6 table load", {15'd0, pc_load, pc_new}, {15'd0, 1'b1, w});
          check("R6 req dropped", {31'd0, vec_rd_req}, 0);
        end else begin
          check("R5 restart target", {15'd0, pc_load, pc_new}, {15'd0, 1'b1, 16'h0038});
        end
      end else begin
        // R2: rejection leaves every action output quiet
        check("R2 no action",
              {27'd0, taken, push_valid, clr_iff1, vec_rd_req, pc_load}, 0);
      end
      quiet();
    end

    // R10: held maskable request, guard cycle between acceptances
    irq_req = 1'b1; iff1_in = 1'b1; int_mode = 2'd1; halted_in = 1'b0; pc_in = 16'h0500;
    step();
    check("R10 first take", {31'd0, taken}, 1);
    step();
    check("R10 guard cycle", {31'd0, taken}, 0);
    step();
    check("R10 retake", {31'd0, taken}, 1);
    quiet();

    // R9: NMI held high is taken once
    nmi_req = 1'b1; iff1_in = 1'b0;
    step();
    check("R9 nmi once taken", {30'd0, taken, nmi_taken}, 3);
    for (int j = 0; j < 3; j++) begin
      step();
      check("R9 nmi held no retake", {31'd0, taken}, 0);
    end
    quiet();

    // R9: NMI edge during a stalled table fetch is remembered
    irq_req = 1'b1; iff1_in = 1'b1; int_mode = 2'd2; i_reg = 8'hC0; bus_vec = 8'h0E;
    step();
    check("R6 fetch start", {31'd0, vec_rd_req}, 1);
    irq_req = 1'b0; nmi_req = 1'b1;
    step();
    check("R9 no take while fetching", {31'd0, taken}, 0);
    step();
    check("R6 stall holds address", {15'd0, vec_rd_req, vec_rd_addr}, {15'd0, 1'b1, 16'hC00E});
    check("R6 stall no load", {31'd0, pc_load}, 0);
    vec_rd_data = 16'hBEEF; vec_rd_ack = 1'b1;
    step();
    vec_rd_ack = 1'b0; nmi_req = 1'b0;
    check("R6 stalled load", {15'd0, pc_load, pc_new}, {15'd0, 1'b1, 16'hBEEF});
    step();
    check("R9 guard before pending nmi", {31'd0, taken}, 0);
    step();
    check("R9 pending nmi taken", {30'd0, taken, nmi_taken}, 3);
    check("R9 pending nmi target", {16'd0, pc_new}, {16'd0, 16'h0066});
    quiet();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule